// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable behavioural model of a single-clock static RAM whose control, address and write-data inputs are all registered on the rising clock edge. Each word is 36 bits wide, split into four 9-bit lanes (eight data bits plus one parity bit per lane). Reads are pipelined. The command is captured on one edge, the array is read and the result is registered on the next edge, and the output-enable input then gates that result without involving the clock.

A burst begins with either of two active-low strobes. The processor strobe always opens with a read cycle and is only honoured while the primary chip enable is asserted. The controller strobe opens with a read or a write, depending on the write controls. While a burst is open and neither strobe is asserted, each cycle continues the burst. The advance input steps the two low address bits with wrap-around; otherwise the address is held. A snooze input forces the device into the deselected state. The memory depth is a parameter, so a small array can be used in test.

Top module: `sbs_sram`

## Requirements
- R1: The device is selected only when ce_n=0, ce2=1 and ce2_n=0. A burst strobe (adsc_n=0, or adsp_n=0 with ce_n=0) under any other enable combination deselects the device. That cycle performs no read or write, it closes any open burst, and its output a cycle later is zero.
- R2: A burst started by adsp_n=0 with ce_n=0 and the device selected is a read of the given address. The write controls are ignored in that cycle.
- R3: When adsp_n=0 and ce_n=1, the processor strobe is ignored. The cycle then behaves as if adsp_n were 1; for example, an open burst continues.
- R4: In a cycle that writes (a controller-strobe start, or a burst continuation), with gw_n=1 and bwe_n=0, lane i is written exactly when bw_n[i]=0. Lane i is bits [9i+8:9i] of din and dout.
- R5: gw_n=0 in a writing cycle writes all four lanes, whatever the values of bwe_n and bw_n.
- R6: A cycle that starts or continues a burst with gw_n=1 and bwe_n=1 is a read.
- R7: Read data for a command captured on edge k appears on dout after edge k+1. Any cycle that is not a read gives dout=0 after its k+1 edge.
- R8: During a burst with no strobe asserted, adv_n=0 adds one to the low two address bits, wrapping within the aligned group of four words. adv_n=1 holds the address.
- R9: While oe_n=1, dout is zero immediately, without any clock edge. It shows the registered read data again as soon as oe_n=0.
- R10: With zz=1 nothing is read or written, and any open burst is closed.
- R11: A write in the cycle right after a read does not disturb the read data already in the pipeline. A read right after a write to the same address returns the new data.
- R12: After reset, dout is zero and no burst is open. Continuation cycles therefore write nothing until a burst is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address captured when a burst starts |
| din | input | 36 | Write data, four 9-bit lanes |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Expansion enable, active high |
| ce2_n | input | 1 | Expansion enable, active low |
| adsp_n | input | 1 | Processor burst strobe, read-only start, active low |
| adsc_n | input | 1 | Controller burst strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Snooze, forces deselect |
| dout | output | 36 | Registered read data gated by oe_n |

## Verification
Each lane of a word carries a distinct value, so a write that lands on the wrong lane or leaves a lane untouched shows up on the next read. Reads started by both strobes are applied, and so are write attempts under every failing chip-enable combination and under snooze. Comparing later read-back values tells an ignored write from a performed one. A burst that advances through a full group of four and then holds separates wrap-around from carry into the upper address bits. A processor strobe given with the primary enable high, in the middle of a burst, shows whether the strobe was ignored or restarted the burst at a new address. Back-to-back read-then-write and write-then-read pairs on the same word separate correct pipelining from read-during-write corruption.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_START = 2'd1,
    CK_CONT  = 2'd2,
    CK_DESEL = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
(
  input  logic      zz,
  input  logic      ce_n,
  input  logic      ce2,
  input  logic      ce2_n,
  input  logic      adsp_n,
  input  logic      adsc_n,
  input  logic      active,
  output cyc_kind_e kind,
  output logic      rd_only
);
  logic sel;
  logic p_ok;
  logic strobe;

  always_comb begin
    sel     = !ce_n && ce2 && !ce2_n;
    p_ok    = !adsp_n && !ce_n;
    strobe  = p_ok || !adsc_n;
    rd_only = p_ok;
    if (zz)
      kind = CK_DESEL;
    else if (strobe && sel)
      kind = CK_START;
    else if (strobe)
      kind = CK_DESEL;
    else if (active)
      kind = CK_CONT;
    else
      kind = CK_NONE;
  end
endmodule

// File: rtl/sbs_lanes.sv
module sbs_lanes #(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             rd_only,
  output logic [LANES-1:0] lane_we
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (rd_only)
        lane_we[i] = 1'b0;
      else if (!gw_n)
        lane_we[i] = 1'b1;
      else
        lane_we[i] = !bwe_n && !bw_n[i];
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 11,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        we,
  output logic [LANES*LANE_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic rd_en;
  assign rd_en = en && (we == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q_d;

    always_ff @(posedge clk) begin
      if (en && we[i])
        mem[addr] <= wdata[i*LANE_W +: LANE_W];
    end

    always_comb begin
      q_d = rd_en ? mem[addr] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i*LANE_W +: LANE_W] <= '0;
      else
        q[i*LANE_W +: LANE_W] <= q_d;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || (we != '0)) |=> (q == '0)); // R7
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [35:0]       din,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              ce2_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              bwe_n,
  input  logic [3:0]        bw_n,
  input  logic              gw_n,
  input  logic              oe_n,
  input  logic              zz,
  output logic [35:0]       dout
);
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= 2'b00;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  cyc_kind_e          kind;
  logic               rd_only;
  logic [LANES-1:0]   lane_we;

  logic               active_q, active_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               cmd_v_q, cmd_v_d;
  logic [LANES-1:0]   cmd_we_q, cmd_we_d;
  logic [WORD_W-1:0]  din_q;
  logic [WORD_W-1:0]  rdata;
  logic [ADDR_W-1:0]  addr_inc;

  sbs_decode u_decode (
    .zz      (zz),
    .ce_n    (ce_n),
    .ce2     (ce2),
    .ce2_n   (ce2_n),
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .active  (active_q),
    .kind    (kind),
    .rd_only (rd_only)
  );

  sbs_lanes #(.LANES(LANES)) u_lanes (
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .rd_only (rd_only),
    .lane_we (lane_we)
  );

  always_comb begin
    addr_inc = addr_q;
    addr_inc[BURST_W-1:0] = addr_q[BURST_W-1:0] + 1'b1;
  end

  always_comb begin
    active_d = active_q;
    addr_d   = addr_q;
    cmd_v_d  = 1'b0;
    cmd_we_d = '0;
    case (kind)
      CK_START: begin
        active_d = 1'b1;
        addr_d   = addr;
        cmd_v_d  = 1'b1;
        cmd_we_d = lane_we;
      end
      CK_CONT: begin
        if (!adv_n)
          addr_d = addr_inc;
        cmd_v_d  = 1'b1;
        cmd_we_d = lane_we;
      end
      CK_DESEL: active_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      cmd_v_q  <= 1'b0;
      cmd_we_q <= '0;
      din_q    <= '0;
    end else begin
      active_q <= active_d;
      addr_q   <= addr_d;
      cmd_v_q  <= cmd_v_d;
      cmd_we_q <= cmd_we_d;
      if (cmd_v_d)
        din_q <= din;
    end
  end

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .rst_n (rst_s),
    .en    (cmd_v_q),
    .addr  (addr_q),
    .wdata (din_q),
    .we    (cmd_we_q),
    .q     (rdata)
  );

  assign dout = oe_n ? '0 : rdata;

  AST_ADSP_READ: assert property (@(posedge clk) disable iff (!rst_s)
    (!zz && !adsp_n && !ce_n) |=> (cmd_we_q == '0)); // R2
  AST_GW_ALL: assert property (@(posedge clk) disable iff (!rst_s)
    (!zz && adsp_n && !adsc_n && !ce_n && ce2 && !ce2_n && !gw_n) |=> (cmd_we_q == '1)); // R5
  AST_DESEL: assert property (@(posedge clk) disable iff (!rst_s)
    (!zz && !adsc_n && !(!ce_n && ce2 && !ce2_n)) |=> (!active_q && !cmd_v_q)); // R1
  AST_SNOOZE: assert property (@(posedge clk) disable iff (!rst_s)
    zz |=> (!active_q && !cmd_v_q)); // R10
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_s)
    (active_q && !zz && adsc_n && (adsp_n || ce_n) && adv_n) |=> $stable(addr_q)); // R8
endmodule

// File: tb/sbs_sram_test.sv
`timescale 1ns/1ps
module sbs_sram_test;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [35:0]   din;
  logic          ce_n, ce2, ce2_n, adsp_n, adsc_n, adv_n, bwe_n, gw_n, oe_n, zz;
  logic [3:0]    bw_n;
  logic [35:0]   dout;

  always #10 clk = ~clk;

  sbs_sram #(.ADDR_W(AW), .BURST_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .ce2(ce2),
    .ce2_n(ce2_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .gw_n(gw_n), .oe_n(oe_n), .zz(zz), .dout(dout)
  );

  typedef struct {
    int          due;
    logic [35:0] exp;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          tick = 0;
  int          nchk = 0;
  int          nbad = 0;
  logic [35:0] shadow [1<<AW];
  logic        m_act = 1'b0;
  logic [AW-1:0] m_addr = '0;

  always @(posedge clk) tick <= tick + 1;

  task automatic check(input logic [35:0] act, input logic [35:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: dout=%h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] pat(input int a, input int s);
    return {9'(a * 5 + s + 9'h101), 9'(a * 3 + s + 9'h0a5), 9'(a + s + 9'h15a), 9'(a * 7 + s + 9'h033)};
  endfunction

  task automatic dflt();
    addr = '0; din = '0; ce_n = 1'b0; ce2 = 1'b1; ce2_n = 1'b0;
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
    gw_n = 1'b1; zz = 1'b0;
  endtask

  task automatic step(input string tag);
    logic sel, pok, strobe, st, ds, ct, op;
    logic [3:0]  ln;
    logic [35:0] ex;
    item_t it;
    sel    = !ce_n && ce2 && !ce2_n;
    pok    = !adsp_n && !ce_n;
    strobe = pok || !adsc_n;
    st = !zz && strobe && sel;
    ds = zz || (strobe && !sel);
    ct = !zz && !strobe && m_act;
    if (st) m_addr = addr;
    else if (ct && !adv_n) m_addr[1:0] = m_addr[1:0] + 2'd1;
    op = st || ct;
    if (!op || pok) ln = 4'h0;
    else if (!gw_n) ln = 4'hF;
    else if (!bwe_n) ln = ~bw_n;
    else ln = 4'h0;
    ex = (op && ln == 4'h0) ? shadow[m_addr] : 36'h0;
    for (int i = 0; i < 4; i++)
      if (ln[i]) shadow[m_addr][i*9 +: 9] = din[i*9 +: 9];
    if (st) m_act = 1'b1;
    else if (ds) m_act = 1'b0;
    it.due = tick + 2; it.exp = ex; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    dflt();
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0 && sb[0].due <= tick) begin
        it = sb.pop_front();
        check(dout, it.exp, it.tag);
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    nchk++; nbad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin : main
    dflt();
    oe_n  = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dout, 36'h0, "R12 reset");

    // R12: no burst open, continuation with writes must not write address 0
    bwe_n = 1'b0; bw_n = 4'h0; din = 36'hFFFFFFFFF; adv_n = 1'b0; step("R12");

    // R5: global write fills all lanes although byte controls say none
    for (int a = 0; a < 8; a++) begin
      adsc_n = 1'b0; addr = AW'(a); din = pat(a, 0); gw_n = 1'b0; bwe_n = 1'b1; bw_n = 4'hF;
      step("R5");
    end
    adsc_n = 1'b0; addr = 6'd0; step("R5 readback");
    adsc_n = 1'b0; addr = 6'd7; step("R5 readback");

    // R2: processor strobe start ignores write controls
    adsp_n = 1'b0; addr = 6'd4; bwe_n = 1'b0; bw_n = 4'h0; gw_n = 1'b0; din = 36'h0; step("R2");
    // R8: advance through group of four with wrap, then hold
    adv_n = 1'b0; step("R8 adv5");
    adv_n = 1'b0; step("R8 adv6");
    adv_n = 1'b0; step("R8 adv7");
    adv_n = 1'b0; step("R8 wrap4");
    adv_n = 1'b1; step("R8 hold");
    adsc_n = 1'b0; addr = 6'd4; step("R2 unchanged");

    // R4: partial byte write on lanes 0 and 2
    adsc_n = 1'b0; addr = 6'd2; bwe_n = 1'b0; bw_n = 4'b1010; din = pat(2, 77); step("R4");
    // R6 and R11: read immediately after write to same address
    adsc_n = 1'b0; addr = 6'd2; step("R6 R11 rd-after-wr");
    adsc_n = 1'b0; addr = 6'd2; bwe_n = 1'b0; bw_n = 4'b0101; din = pat(2, 200); step("R4 other lanes");
    adsc_n = 1'b0; addr = 6'd2; step("R4 readback");

    // R11: write right after read keeps the read data
    adsp_n = 1'b0; addr = 6'd3; step("R11 read old");
    bwe_n = 1'b0; bw_n = 4'h0; din = pat(3, 9); step("R11 write next");
    adsc_n = 1'b0; addr = 6'd3; step("R11 readback");

    // R3: processor strobe with ce_n high is ignored; burst continues 3 -> 0
    adsp_n = 1'b0; ce_n = 1'b1; addr = 6'd9; adv_n = 1'b0; step("R3");

    // R1: deselect under each failing enable combination
    adsc_n = 1'b0; addr = 6'd5; ce2 = 1'b0; gw_n = 1'b0; din = 36'h0; step("R1 ce2");
    bwe_n = 1'b0; bw_n = 4'h0; adv_n = 1'b0; step("R1 closed");
    adsc_n = 1'b0; addr = 6'd5; ce2_n = 1'b1; gw_n = 1'b0; step("R1 ce2_n");
    adsc_n = 1'b0; addr = 6'd5; ce_n = 1'b1; gw_n = 1'b0; step("R1 ce_n");
    adsp_n = 1'b0; addr = 6'd5; ce2_n = 1'b1; step("R1 adsp");
    adsc_n = 1'b0; addr = 6'd5; step("R1 unchanged");

    // R10: snooze blocks a write and closes the burst
    zz = 1'b1; adsc_n = 1'b0; addr = 6'd6; gw_n = 1'b0; din = 36'h0; step("R10");
    bwe_n = 1'b0; bw_n = 4'h0; step("R10 closed");
    adsc_n = 1'b0; addr = 6'd6; step("R10 unchanged");

    // R9: asynchronous output enable on the read just returned
    adsc_n = 1'b0; addr = 6'd1; step("R7");
    step("R7 idle");
    #2 oe_n = 1'b1;
    #1 check(dout, 36'h0, "R9 off");
    oe_n = 1'b0;
    #1 check(dout, pat(1, 0), "R9 on");

    repeat (4) step("drain");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule